// File: doc/BRIEF.md
# Character-Serial Drum Transfer Controller

The block controls two word-organised storage units and moves their contents one character at a time to or from an I/O channel. Each unit holds 2^WORD_AW words of eight characters in its own internal RAM. A command names a unit, a two-bit channel number, a direction and a starting word. The command is taken only when the chosen unit is ready; otherwise a busy pulse answers it and nothing changes.

An accepted unit waits a programmable start latency. It then offers one character handshake per step, with a programmable gap between steps. On each handshake the channel either takes or supplies a character, or it signals that the transfer is over. The character address starts at the word address times eight and advances by one per transfer. Running off the end of the store stops the unit with an error. Each unit drives its own ready bit into a shared status vector, so both units can work at once on different channels.

After reset each unit sweeps its RAM to zero before it reports ready, so reads of untouched locations return zero.

Top module: `drum_xfer_ctrl`

## Requirements
- R1: During reset and for the sweep after it, `unit_ready`, `ch_req`, `ch_end`, `ch_err`, `unit_rd` and `unit_wr` are all 0. Each unit raises its `unit_ready` bit 8*2^WORD_AW cycles after reset is released. Every character then reads as zero until it is written.
- R2: A `cmd_valid` to a ready unit gives a one-cycle `cmd_accept` in the next cycle. In that same cycle the unit's ready bit clears and the unit's `ch_num` field shows `cmd_chan`. Exactly one of `unit_rd` or `unit_wr` is set: `cmd_read`=1 means read (store to channel) and 0 means write (channel to store).
- R3: A `cmd_valid` whose unit is not ready gives a one-cycle `cmd_busy` in the next cycle, with no `cmd_accept` and no change to any unit.
- R4: The first transfer uses character address `cmd_word`*8. The unit's `ch_req` first rises START_CYC cycles after the clock edge that accepted the command.
- R5: On a read handshake, `ch_rd_char` holds the stored character at the current address while `ch_req` is high. The address then advances by one, and the next `ch_req` follows STEP_CYC cycles after the previous one. Each `ch_req` lasts exactly one cycle.
- R6: On a write handshake without `ch_last`, the value on `ch_wr_char` is stored at the current address, and a later read returns it.
- R7: If `ch_last` is high during a `ch_req` cycle, no character is transferred. In the next cycle `ch_end` pulses with `ch_err` low, the ready bit returns and `unit_rd`/`unit_wr` clear.
- R8: A transfer at the last character address (8*2^WORD_AW-1) without `ch_last` is completed. In the next cycle `ch_end` and `ch_err` pulse together and the unit returns to ready.
- R9: The two units run independently. Both may be busy at once on different channels, with separate ready bits, handshakes and end pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_unit | input | SEL_W | Unit select |
| cmd_chan | input | 2 | Channel number for the command |
| cmd_read | input | 1 | 1 = read (store to channel), 0 = write |
| cmd_word | input | WORD_AW | Starting word address |
| cmd_accept | output | 1 | Command taken (one cycle) |
| cmd_busy | output | 1 | Command refused, unit not ready (one cycle) |
| unit_ready | output | NUM_UNITS | Per-unit ready/presence status bit |
| unit_rd | output | NUM_UNITS | Unit executing a read |
| unit_wr | output | NUM_UNITS | Unit executing a write |
| ch_num | output | 2*NUM_UNITS | Stored channel number per unit |
| ch_req | output | NUM_UNITS | Character handshake strobe per unit |
| ch_rd_char | output | CHAR_W*NUM_UNITS | Character offered to the channel on a read |
| ch_wr_char | input | CHAR_W*NUM_UNITS | Character supplied by the channel on a write |
| ch_last | input | NUM_UNITS | Channel ends the transfer at this handshake |
| ch_end | output | NUM_UNITS | Transfer finished (one cycle) |
| ch_err | output | NUM_UNITS | Overrun error, pulses with ch_end |

## Verification
Each result has a fixed time after its cause. `cmd_accept` or `cmd_busy` follows one cycle after `cmd_valid`. The first `ch_req` follows START_CYC cycles after the accepting edge, and later ones come every STEP_CYC cycles. `ch_end`, `ch_err` and the ready bit follow one cycle after the handshake that closes the transfer, and the ready bits come up 8*2^WORD_AW cycles after reset. The bench updates a behavioural model of units, counters and character stores on each rising edge, using the inputs the design sees. It compares every output with the model on each falling edge, so a result early or late by one cycle shows as a mismatch. Explicit checks count the cycles from acceptance to the first strobe, and confirm refusal, end, overrun and the concurrent operation of both units.

// File: rtl/drum_pkg.sv
package drum_pkg;
  typedef enum logic [1:0] {
    U_CLEAR = 2'd0,
    U_IDLE  = 2'd1,
    U_WAIT  = 2'd2,
    U_XFER  = 2'd3
  } unit_state_t;
endpackage

// File: rtl/drum_char_ram.sv
module drum_char_ram #(
  parameter int DW = 6,
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // single port, read-first, registered output
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/drum_unit.sv
module drum_unit
  import drum_pkg::*;
#(
  parameter int CHAR_W    = 6,
  parameter int WORD_AW   = 4,
  parameter int START_CYC = 100,
  parameter int STEP_CYC  = 40
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               start_rd,
  input  logic [1:0]         start_chan,
  input  logic [WORD_AW-1:0] start_word,
  output logic               ready,
  output logic               rd_act,
  output logic               wr_act,
  output logic [1:0]         chan,
  output logic               req,
  output logic [CHAR_W-1:0]  rd_char,
  input  logic [CHAR_W-1:0]  wr_char,
  input  logic               last,
  output logic               done,
  output logic               err
);
  localparam int CHAR_AW = WORD_AW + 3;
  localparam int CNT_W   = $clog2(START_CYC + STEP_CYC + 1);
  localparam logic [CHAR_AW-1:0] LAST_ADDR = {CHAR_AW{1'b1}};

  unit_state_t        st;
  logic [CHAR_AW-1:0] addr;
  logic [CNT_W-1:0]   cnt;
  logic               mem_we;
  logic [CHAR_W-1:0]  mem_wd;

  initial begin
    if (START_CYC < 1) $error("START_CYC must be at least 1");
    if (STEP_CYC < 2)  $error("STEP_CYC must be at least 2");
  end

  always_comb begin
    mem_we = (st == U_CLEAR) || (st == U_XFER && wr_act && !last);
    mem_wd = (st == U_CLEAR) ? '0 : wr_char;
  end

  drum_char_ram #(.DW(CHAR_W), .AW(CHAR_AW)) u_ram (
    .clk  (clk),
    .we   (mem_we),
    .addr (addr),
    .wdata(mem_wd),
    .rdata(rd_char)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= U_CLEAR;
      addr   <= '0;
      cnt    <= '0;
      ready  <= 1'b0;
      rd_act <= 1'b0;
      wr_act <= 1'b0;
      chan   <= '0;
      req    <= 1'b0;
      done   <= 1'b0;
      err    <= 1'b0;
    end else begin
      req  <= 1'b0;
      done <= 1'b0;
      err  <= 1'b0;
      case (st)
        U_CLEAR: begin
          if (addr == LAST_ADDR) begin
            st    <= U_IDLE;
            addr  <= '0;
            ready <= 1'b1;
          end else begin
            addr <= addr + 1'b1;
          end
        end
        U_IDLE: begin
          if (start) begin
            st     <= U_WAIT;
            ready  <= 1'b0;
            rd_act <= start_rd;
            wr_act <= !start_rd;
            chan   <= start_chan;
            addr   <= {start_word, 3'b000};
            cnt    <= CNT_W'(START_CYC);
          end
        end
        U_WAIT: begin
          if (cnt == CNT_W'(1)) begin
            st  <= U_XFER;
            req <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        U_XFER: begin
          if (last || addr == LAST_ADDR) begin
            st     <= U_IDLE;
            ready  <= 1'b1;
            rd_act <= 1'b0;
            wr_act <= 1'b0;
            done   <= 1'b1;
            err    <= !last;
          end else begin
            st   <= U_WAIT;
            addr <= addr + 1'b1;
            cnt  <= CNT_W'(STEP_CYC - 1);
          end
        end
        default: st <= U_IDLE;
      endcase
    end
  end

  // R2: an active unit carries exactly one direction flag
  assert_dir_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    (!ready && st != U_CLEAR) |-> $onehot({rd_act, wr_act}));

  // R5: a handshake strobe lasts one cycle
  assert_req_single_R5: assert property (@(posedge clk) disable iff (rst)
    req |=> !req);

  // R7: completion returns the unit to ready with direction flags cleared
  assert_ready_on_end_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> (ready && !rd_act && !wr_act));

  // R8: an error is only reported together with end
  assert_err_with_end_R8: assert property (@(posedge clk) disable iff (rst)
    err |-> done);

  // R7: end follows a handshake by one cycle
  assert_end_after_req_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(req));
endmodule

// File: rtl/drum_xfer_ctrl.sv
module drum_xfer_ctrl #(
  parameter int NUM_UNITS = 2,
  parameter int CHAR_W    = 6,
  parameter int WORD_AW   = 4,
  parameter int START_CYC = 100,
  parameter int STEP_CYC  = 40,
  localparam int SEL_W    = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        cmd_valid,
  input  logic [SEL_W-1:0]            cmd_unit,
  input  logic [1:0]                  cmd_chan,
  input  logic                        cmd_read,
  input  logic [WORD_AW-1:0]          cmd_word,
  output logic                        cmd_accept,
  output logic                        cmd_busy,
  output logic [NUM_UNITS-1:0]        unit_ready,
  output logic [NUM_UNITS-1:0]        unit_rd,
  output logic [NUM_UNITS-1:0]        unit_wr,
  output logic [2*NUM_UNITS-1:0]      ch_num,
  output logic [NUM_UNITS-1:0]        ch_req,
  output logic [CHAR_W*NUM_UNITS-1:0] ch_rd_char,
  input  logic [CHAR_W*NUM_UNITS-1:0] ch_wr_char,
  input  logic [NUM_UNITS-1:0]        ch_last,
  output logic [NUM_UNITS-1:0]        ch_end,
  output logic [NUM_UNITS-1:0]        ch_err
);
  logic [NUM_UNITS-1:0] take;

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    assign take[u] = cmd_valid && (cmd_unit == SEL_W'(u)) && unit_ready[u];

    drum_unit #(
      .CHAR_W   (CHAR_W),
      .WORD_AW  (WORD_AW),
      .START_CYC(START_CYC),
      .STEP_CYC (STEP_CYC)
    ) u_unit (
      .clk       (clk),
      .rst       (rst),
      .start     (take[u]),
      .start_rd  (cmd_read),
      .start_chan(cmd_chan),
      .start_word(cmd_word),
      .ready     (unit_ready[u]),
      .rd_act    (unit_rd[u]),
      .wr_act    (unit_wr[u]),
      .chan      (ch_num[2*u +: 2]),
      .req       (ch_req[u]),
      .rd_char   (ch_rd_char[CHAR_W*u +: CHAR_W]),
      .wr_char   (ch_wr_char[CHAR_W*u +: CHAR_W]),
      .last      (ch_last[u]),
      .done      (ch_end[u]),
      .err       (ch_err[u])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_accept <= 1'b0;
      cmd_busy   <= 1'b0;
    end else begin
      cmd_accept <= |take;
      cmd_busy   <= cmd_valid && !(|take);
    end
  end

  // R2: an acceptance answers a command from the cycle before
  assert_accept_cause_R2: assert property (@(posedge clk) disable iff (rst)
    cmd_accept |-> $past(cmd_valid));

  // R3: a refusal never coincides with an acceptance
  assert_busy_excl_R3: assert property (@(posedge clk) disable iff (rst)
    !(cmd_accept && cmd_busy));

  // R9: each unit raises at most one error at a time, only with its end
  assert_err_subset_R9: assert property (@(posedge clk) disable iff (rst)
    ((ch_err & ~ch_end) == '0));
endmodule

// File: tb/drum_xfer_ctrl_tb.sv
module drum_xfer_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NU    = 2;
  localparam int CW    = 6;
  localparam int WAW   = 4;
  localparam int SCYC  = 6;
  localparam int TCYC  = 3;
  localparam int CHARS = 8 << WAW;

  logic clk = 0;
  logic rst = 1;
  logic cmd_valid = 0;
  logic [0:0] cmd_unit = 0;
  logic [1:0] cmd_chan = 0;
  logic cmd_read = 0;
  logic [WAW-1:0] cmd_word = 0;
  logic cmd_accept, cmd_busy;
  logic [NU-1:0] unit_ready, unit_rd, unit_wr, ch_req, ch_end, ch_err;
  logic [2*NU-1:0] ch_num;
  logic [CW*NU-1:0] ch_rd_char;
  logic [CW*NU-1:0] ch_wr_char = '0;
  logic [NU-1:0] ch_last = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  drum_xfer_ctrl #(.NUM_UNITS(NU), .CHAR_W(CW), .WORD_AW(WAW),
                   .START_CYC(SCYC), .STEP_CYC(TCYC)) u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_unit(cmd_unit),
    .cmd_chan(cmd_chan), .cmd_read(cmd_read), .cmd_word(cmd_word),
    .cmd_accept(cmd_accept), .cmd_busy(cmd_busy), .unit_ready(unit_ready),
    .unit_rd(unit_rd), .unit_wr(unit_wr), .ch_num(ch_num), .ch_req(ch_req),
    .ch_rd_char(ch_rd_char), .ch_wr_char(ch_wr_char), .ch_last(ch_last),
    .ch_end(ch_end), .ch_err(ch_err));

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  // reference model: 0 sweep, 1 idle, 2 waiting, 3 handshake
  int mmem [NU][CHARS];
  int mst [NU], mcnt [NU], maddr [NU], mclr [NU], mchan [NU], mchar [NU];
  bit mrd [NU], mready [NU], mreq [NU], mend [NU], merr [NU];
  bit macc, mbusy;
  // channel responder state
  int nstr [NU], lim [NU], seed [NU];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    bit take [NU];
    if (rst) begin
      for (int u = 0; u < NU; u++) begin
        mst[u] = 0; mclr[u] = 0; maddr[u] = 0; mcnt[u] = 0; mrd[u] = 0;
        mready[u] = 0; mreq[u] = 0; mend[u] = 0; merr[u] = 0; mchan[u] = 0;
        for (int a = 0; a < CHARS; a++) mmem[u][a] = 0;
      end
      macc = 0; mbusy = 0;
    end else begin
      for (int u = 0; u < NU; u++) take[u] = cmd_valid && (int'(cmd_unit) == u) && mready[u];
      macc = take[0] || take[1];
      mbusy = cmd_valid && !macc;
      for (int u = 0; u < NU; u++) begin
        mreq[u] = 0; mend[u] = 0; merr[u] = 0;
        case (mst[u])
          0: begin
            mclr[u]++;
            if (mclr[u] == CHARS) begin mst[u] = 1; mready[u] = 1; end
          end
          1: if (take[u]) begin
            mst[u] = 2; mready[u] = 0; mrd[u] = cmd_read; mchan[u] = cmd_chan;
            maddr[u] = int'(cmd_word) * 8; mcnt[u] = SCYC;
          end
          2: if (mcnt[u] == 1) begin
            mst[u] = 3; mreq[u] = 1; mchar[u] = mmem[u][maddr[u]];
          end else mcnt[u]--;
          default: begin
            if (ch_last[u]) begin
              mst[u] = 1; mready[u] = 1; mend[u] = 1;
            end else begin
              if (!mrd[u]) mmem[u][maddr[u]] = int'(ch_wr_char[CW*u +: CW]);
              if (maddr[u] == CHARS-1) begin
                mst[u] = 1; mready[u] = 1; mend[u] = 1; merr[u] = 1;
              end else begin
                maddr[u]++; mst[u] = 2; mcnt[u] = TCYC - 1;
              end
            end
          end
        endcase
      end
    end
  end

  // compare on every falling edge, then drive the channel responses
  always @(negedge clk) begin
    if (!rst) begin
      chk(cmd_accept == macc, "R2 cmd_accept", cmd_accept, macc);
      chk(cmd_busy == mbusy, "R3 cmd_busy", cmd_busy, mbusy);
      for (int u = 0; u < NU; u++) begin
        bit act;
        act = (mst[u] == 2 || mst[u] == 3);
        chk(unit_ready[u] == mready[u], "R1/R2 unit_ready", unit_ready[u], mready[u]);
        chk(unit_rd[u] == (act && mrd[u]), "R2 unit_rd", unit_rd[u], act && mrd[u]);
        chk(unit_wr[u] == (act && !mrd[u]), "R2 unit_wr", unit_wr[u], act && !mrd[u]);
        chk(ch_req[u] == mreq[u], "R4/R5 ch_req", ch_req[u], mreq[u]);
        chk(ch_end[u] == mend[u], "R7 ch_end", ch_end[u], mend[u]);
        chk(ch_err[u] == merr[u], "R8 ch_err", ch_err[u], merr[u]);
        if (act) chk(int'(ch_num[2*u +: 2]) == mchan[u], "R2 ch_num", ch_num[2*u +: 2], mchan[u]);
        if (mreq[u] && mrd[u])
          chk(int'(ch_rd_char[CW*u +: CW]) == mchar[u], "R5/R6 ch_rd_char",
              ch_rd_char[CW*u +: CW], mchar[u]);
      end
    end
    for (int u = 0; u < NU; u++) begin
      if (ch_req[u]) begin
        ch_last[u] = (nstr[u] == lim[u]);
        ch_wr_char[CW*u +: CW] = CW'(seed[u] + nstr[u]);
        nstr[u]++;
      end else begin
        ch_last[u] = 0;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic issue(input int u, input bit rd, input int chn, input int word,
                       input int limit, input int sd);
    @(negedge clk);
    nstr[u] = 0; lim[u] = limit; seed[u] = sd;
    cmd_valid = 1; cmd_unit = 1'(u); cmd_read = rd; cmd_chan = 2'(chn); cmd_word = WAW'(word);
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic wait_idle(input int u);
    while (mst[u] != 1) @(negedge clk);
  endtask

  initial begin
    int n;
    bit saw_err;
    for (int u = 0; u < NU; u++) begin nstr[u] = 0; lim[u] = 0; seed[u] = 0; end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: outputs quiet during the sweep
    chk(unit_ready == 0 && ch_req == 0 && ch_end == 0 && ch_err == 0 &&
        unit_rd == 0 && unit_wr == 0, "R1 quiet after reset",
        {unit_ready, ch_req, ch_end, ch_err}, 0);
    repeat (CHARS - 3) @(negedge clk);
    chk(unit_ready == 0, "R1 not ready before sweep ends", unit_ready, 0);
    repeat (2) @(negedge clk);
    chk(unit_ready == 2'b11, "R1 ready after sweep", unit_ready, 3);

    // R1: untouched characters read zero (model compares each char)
    issue(0, 1, 0, 0, 8, 0);
    wait_idle(0);

    // R6 and R4: write five characters from word 2, measure start latency
    issue(0, 0, 3, 2, 5, 10);
    chk(cmd_accept == 1, "R2 accept write", cmd_accept, 1);
    chk(unit_wr[0] == 1 && unit_rd[0] == 0, "R2 write flag", {unit_rd[0], unit_wr[0]}, 1);
    chk(ch_num[1:0] == 2'd3, "R2 channel stored", ch_num[1:0], 3);
    n = 0;
    while (!ch_req[0] && n < 50) begin @(negedge clk); n++; end
    chk(n == SCYC, "R4 start latency", n, SCYC);
    wait_idle(0);

    // R5/R6: read back word 2, five written plus three zero characters
    issue(0, 1, 1, 2, 8, 0);
    chk(unit_rd[0] == 1 && unit_wr[0] == 0, "R2 read flag", {unit_rd[0], unit_wr[0]}, 2);
    wait_idle(0);

    // R3: second command to a busy unit is refused
    issue(1, 0, 2, 3, 4, 20);
    issue(1, 1, 0, 0, 4, 0);
    chk(cmd_busy == 1 && cmd_accept == 0, "R3 refused while active",
        {cmd_busy, cmd_accept}, 2);
    chk(unit_wr[1] == 1 && ch_num[3:2] == 2'd2, "R3 active command unchanged",
        {unit_wr[1], ch_num[3:2]}, 6);
    wait_idle(1);

    // R8: overrun from the last word
    issue(1, 0, 2, 15, 100, 33);
    saw_err = 0;
    while (mst[1] != 1) begin
      @(negedge clk);
      if (ch_end[1] && ch_err[1]) saw_err = 1;
    end
    chk(saw_err, "R8 overrun end with error", saw_err, 1);

    // R9: both units active on different channels at once
    issue(0, 1, 1, 2, 6, 0);
    issue(1, 1, 2, 15, 20, 0);
    chk(unit_ready == 2'b00, "R9 both units busy", unit_ready, 0);
    chk(ch_num == 4'b1001, "R9 per-unit channels", ch_num, 9);
    wait_idle(0);
    wait_idle(1);
    chk(unit_ready == 2'b11, "R9 both ready again", unit_ready, 3);

    // R7: end on the very first handshake transfers nothing
    issue(0, 0, 0, 5, 0, 50);
    saw_err = 0;
    while (mst[0] != 1) begin
      @(negedge clk);
      if (ch_err[0]) saw_err = 1;
    end
    chk(!saw_err, "R7 end without error", saw_err, 0);
    issue(0, 1, 0, 5, 1, 0);
    wait_idle(0);

    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule